// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit for Lock Primitives

This block owns a small word-addressed memory and serves several requesters that need indivisible read-modify-write access to it. Besides plain load and store, it offers swap, test-and-set, fetch-and-increment and a linked-load / conditional-store pair. These are the usual building blocks for spin locks, counters and lock-free updates. Each requester holds one link reservation. A conditional store only succeeds while that reservation is still intact.

Requesters raise a request with an opcode, a word address and a data word, and hold it until their response pulse appears. A round-robin arbiter picks one request at a time. The chosen operation reads, computes and writes back with nothing from another requester in between. The old value, or the success flag for a conditional store, returns on a shared data bus, qualified by a one-hot response vector.

Top module: `amo_unit`

## Requirements
- R1: After reset, no response is asserted, every memory word reads 0 and no requester holds a link reservation.
- R2: At most one response bit is high in any cycle. A request to an idle unit is answered on the second rising edge after it is first sampled. A response is only given to a requester whose request is high.
- R3: When several requests are pending, service rotates. The next requester served is the first pending one found by counting upward, with wrap-around, from the one served last. Requester 0 is first after reset.
- R4: Opcode 0 (load) returns the word and leaves memory unchanged. Opcode 1 (store) writes the data word and returns 0.
- R5: Opcode 2 (swap) writes the data word and returns the previous word.
- R6: Opcode 3 (test-and-set) returns the previous word. It writes 1 only if that word was 0 and otherwise leaves memory unchanged.
- R7: Opcode 4 (fetch-and-increment) returns the previous word and stores it plus one, wrapping to 0 from all-ones.
- R8: Opcode 5 (linked load) returns the word and records a reservation for the issuing requester on that address, replacing any earlier one.
- R9: Opcode 6 (conditional store) succeeds when the issuer holds a reservation on the same address. It then writes the data word and returns 1.
- R10: A conditional store without a matching reservation returns 0 and leaves memory unchanged.
- R11: Every write to an address, from any requester and of any opcode, cancels all reservations on that address. Reservations on other addresses survive.
- R12: A conditional store always cancels the issuer's own reservation, so a second one without a new linked load fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_REQ | Per-requester request, held until its response |
| req_op | input | 3*N_REQ | Per-requester opcode, 3 bits each |
| req_addr | input | ADDR_W*N_REQ | Per-requester word address |
| req_wdata | input | DATA_W*N_REQ | Per-requester data word |
| rsp_valid | output | N_REQ | One-hot response pulse |
| rsp_data | output | DATA_W | Old value or conditional-store flag |

## Verification
A reservation that is wrongly kept or wrongly dropped is not visible until the next conditional store from that requester. That store then returns the wrong flag, and the store or the data it overwrites shows up on the next load. The bench therefore follows every interfering write with the conditional stores and reads that expose it. An arbitration pointer that is off by one shows in the order of the very next set of contending responses. A memory or arithmetic fault shows in the first response from that address, because every response is compared against a reference model.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FINC  = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } amo_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EXEC = 1'b1
  } amo_state_e;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req,
  input  logic             adv,
  output logic             gnt_vld,
  output logic [IDX_W-1:0] gnt_idx
);
  logic [IDX_W-1:0] last_q, last_d;

  // search upward from the slot after the last one served
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = last_q;
    for (int k = 1; k <= N_REQ; k++) begin
      if (!gnt_vld && req[(int'(last_q) + k) % N_REQ]) begin
        gnt_vld = 1'b1;
        gnt_idx = IDX_W'((int'(last_q) + k) % N_REQ);
      end
    end
  end

  always_comb begin
    last_d = last_q;
    if (adv) last_d = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IDX_W'(N_REQ - 1);
    else        last_q <= last_d;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_op_e           op,
  input  logic [DATA_W-1:0] rd_word,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sc_ok,
  output logic              we,
  output logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    we     = 1'b0;
    wr_val = wdata;
    result = rd_word;
    case (op)
      OP_STORE: begin
        we     = 1'b1;
        result = '0;
      end
      OP_SWAP: we = 1'b1;
      OP_TAS: begin
        we     = (rd_word == '0);
        wr_val = DATA_W'(1);
      end
      OP_FINC: begin
        we     = 1'b1;
        wr_val = rd_word + DATA_W'(1);
      end
      OP_SC: begin
        we     = sc_ok;
        result = sc_ok ? DATA_W'(1) : '0;
      end
      default: ;  // load, linked load, reserved: read only
    endcase
  end
endmodule

// File: rtl/amo_resv_table.sv
module amo_resv_table
  import amo_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    exec,
  input  logic [IDX_W-1:0]        req_idx,
  input  amo_op_e                 op,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_en,
  output logic                    sc_ok,
  output logic [N_REQ-1:0]        resv_vld,
  output logic [ADDR_W*N_REQ-1:0] resv_addr
);
  for (genvar g = 0; g < N_REQ; g++) begin : g_slot
    logic              vld_q, vld_d;
    logic [ADDR_W-1:0] adr_q, adr_d;
    logic              own;

    assign own = exec && (req_idx == IDX_W'(g));

    always_comb begin
      vld_d = vld_q;
      adr_d = adr_q;
      if (wr_en && (adr_q == addr)) vld_d = 1'b0;
      if (own && (op == OP_LL)) begin
        vld_d = 1'b1;
        adr_d = addr;
      end
      if (own && (op == OP_SC)) vld_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        adr_q <= '0;
      end else begin
        vld_q <= vld_d;
        adr_q <= adr_d;
      end
    end

    assign resv_vld[g]                       = vld_q;
    assign resv_addr[g*ADDR_W +: ADDR_W]     = adr_q;
  end

  assign sc_ok = resv_vld[req_idx] &&
                 (resv_addr[int'(req_idx)*ADDR_W +: ADDR_W] == addr);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_REQ-1:0]        req_valid,
  input  logic [OP_W*N_REQ-1:0]   req_op,
  input  logic [ADDR_W*N_REQ-1:0] req_addr,
  input  logic [DATA_W*N_REQ-1:0] req_wdata,
  output logic [N_REQ-1:0]        rsp_valid,
  output logic [DATA_W-1:0]       rsp_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  amo_state_e        state_q, state_d;
  logic [IDX_W-1:0]  owner_q;
  amo_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [N_REQ-1:0]  rsp_vld_q, rsp_vld_d;
  logic [DATA_W-1:0] rsp_data_q;
  logic [DATA_W-1:0] mem_q [DEPTH];

  logic [N_REQ-1:0]  req_elig;
  logic              gnt_vld;
  logic [IDX_W-1:0]  gnt_idx;
  logic              cap_en;
  logic              exec_w;
  logic [DATA_W-1:0] rd_word;
  logic              alu_we;
  logic [DATA_W-1:0] alu_wval;
  logic [DATA_W-1:0] alu_res;
  logic              mem_we;
  logic              sc_ok;
  logic [N_REQ-1:0]        resv_vld;
  logic [ADDR_W*N_REQ-1:0] resv_addr;

  // a requester is not re-taken in the cycle its answer is shown
  assign req_elig = req_valid & ~rsp_vld_q;
  assign cap_en   = (state_q == ST_IDLE) && gnt_vld;
  assign exec_w   = (state_q == ST_EXEC);
  assign rd_word  = mem_q[addr_q];
  assign mem_we   = exec_w && alu_we;

  amo_rr_arb #(.N_REQ(N_REQ)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_elig),
    .adv     (cap_en),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op_q),
    .rd_word (rd_word),
    .wdata   (wdata_q),
    .sc_ok   (sc_ok),
    .we      (alu_we),
    .wr_val  (alu_wval),
    .result  (alu_res)
  );

  amo_resv_table #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_resv (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec      (exec_w),
    .req_idx   (owner_q),
    .op        (op_q),
    .addr      (addr_q),
    .wr_en     (mem_we),
    .sc_ok     (sc_ok),
    .resv_vld  (resv_vld),
    .resv_addr (resv_addr)
  );

  always_comb begin
    state_d   = state_q;
    rsp_vld_d = '0;
    case (state_q)
      ST_IDLE: if (gnt_vld) state_d = ST_EXEC;
      ST_EXEC: begin
        rsp_vld_d[owner_q] = 1'b1;
        state_d            = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rsp_vld_q <= '0;
    end else begin
      state_q   <= state_d;
      rsp_vld_q <= rsp_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= '0;
      op_q    <= OP_LOAD;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      owner_q <= gnt_idx;
      op_q    <= amo_op_e'(req_op[int'(gnt_idx)*OP_W +: OP_W]);
      addr_q  <= req_addr[int'(gnt_idx)*ADDR_W +: ADDR_W];
      wdata_q <= req_wdata[int'(gnt_idx)*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rsp_data_q <= '0;
    else if (exec_w) rsp_data_q <= alu_res;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem_q[w] <= '0;
    end else if (mem_we) begin
      mem_q[addr_q] <= alu_wval;
    end
  end

  assign rsp_valid = rsp_vld_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk
  import amo_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_REQ-1:0]        req_valid,
  input logic [N_REQ-1:0]        rsp_valid,
  input logic [DATA_W-1:0]       rsp_data,
  input logic                    exec_w,
  input amo_op_e                 op_q,
  input logic [IDX_W-1:0]        owner_q,
  input logic [ADDR_W-1:0]       addr_q,
  input logic [DATA_W-1:0]       rd_word,
  input logic                    mem_we,
  input logic [N_REQ-1:0]        resv_vld,
  input logic [ADDR_W*N_REQ-1:0] resv_addr
);
  a_r2_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  for (genvar g = 0; g < N_REQ; g++) begin : g_chk
    a_r2_rsp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[g] |-> $past(req_valid[g]));

    a_r11_write_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !(resv_vld[g] &&
                   (resv_addr[g*ADDR_W +: ADDR_W] == $past(addr_q))));
  end

  a_r6_tas_held_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && (op_q == OP_TAS) && (rd_word != '0)) |-> !mem_we);

  a_r9_sc_flag_bool: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rsp_valid) && (op_q == OP_SC)) |-> (rsp_data <= DATA_W'(1)));

  a_r12_sc_drops_own: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && (op_q == OP_SC)) |=> !resv_vld[$past(owner_q)]);

  a_r4_load_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_w && ((op_q == OP_LOAD) || (op_q == OP_LL))) |-> !mem_we);
endmodule

bind amo_unit amo_unit_chk #(
  .N_REQ (N_REQ),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .exec_w    (exec_w),
  .op_q      (op_q),
  .owner_q   (owner_q),
  .addr_q    (addr_q),
  .rd_word   (rd_word),
  .mem_we    (mem_we),
  .resv_vld  (resv_vld),
  .resv_addr (resv_addr)
);

// File: tb/amo_unit_tb.sv
`timescale 1ns/1ps
module amo_unit_tb;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req_valid;
  logic [3*N-1:0]  req_op;
  logic [AW*N-1:0] req_addr;
  logic [DW*N-1:0] req_wdata;
  logic [N-1:0]  rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  int done_cnt [N];
  logic [DW-1:0] last_rsp [N];
  int order_q [$];
  int last_served = N - 1;

  // reference model state
  logic [DW-1:0] mmem [1<<AW];
  bit            mrv  [N];
  int            mra  [N];
  int            cop  [N];
  int            ca   [N];
  logic [DW-1:0] cd   [N];

  amo_unit #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_for(int op, logic [DW-1:0] e);
    case (op)
      0, 1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return (e == 1) ? "R9" : "R10";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [DW-1:0] model(int r);
    int a;
    logic [DW-1:0] old, res, nv;
    bit wr;
    a = ca[r]; old = mmem[a]; res = old; nv = '0; wr = 0;
    case (cop[r])
      1: begin res = '0; wr = 1; nv = cd[r]; end
      2: begin wr = 1; nv = cd[r]; end
      3: if (old == 0) begin wr = 1; nv = 1; end
      4: begin wr = 1; nv = old + 1; end
      5: begin mrv[r] = 1; mra[r] = a; end
      6: begin
        if (mrv[r] && mra[r] == a) begin res = 1; wr = 1; nv = cd[r]; end
        else res = 0;
        mrv[r] = 0;
      end
      default: ;
    endcase
    if (wr) begin
      mmem[a] = nv;
      for (int k = 0; k < N; k++) if (mrv[k] && mra[k] == a) mrv[k] = 0;
    end
    return res;
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if ($countones(rsp_valid) > 1) begin
        checks++; fails++;
        $display("FAIL R2 several responses: got %b expected onehot", rsp_valid);
      end
      for (int r = 0; r < N; r++) begin
        if (rsp_valid[r]) begin
          if (!req_valid[r]) begin
            checks++; fails++;
            $display("FAIL R2 response to idle requester %0d: got 1 expected 0", r);
          end else begin
            logic [DW-1:0] e;
            e = model(r);
            check(tag_for(cop[r], e), rsp_data, e, $sformatf("response req%0d op%0d", r, cop[r]));
            last_rsp[r] = rsp_data;
            order_q.push_back(r);
            last_served = r;
            req_valid[r] = 1'b0;
            done_cnt[r]++;
          end
        end
      end
    end
  end

  task automatic post(int r, int op, int a, logic [DW-1:0] d);
    cop[r] = op; ca[r] = a; cd[r] = d;
    req_op[r*3 +: 3]     = 3'(op);
    req_addr[r*AW +: AW] = AW'(a);
    req_wdata[r*DW +: DW] = d;
    req_valid[r] = 1'b1;
  endtask

  task automatic run(int r, int op, int a, logic [DW-1:0] d, output logic [DW-1:0] got);
    int s;
    @(negedge clk);
    s = done_cnt[r];
    post(r, op, a, d);
    wait (done_cnt[r] != s);
    got = last_rsp[r];
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] g;
    int s [N];
    int exp_r, zeros;
    req_valid = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    for (int i = 0; i < (1<<AW); i++) mmem[i] = '0;
    for (int i = 0; i < N; i++) begin done_cnt[i] = 0; mrv[i] = 0; mra[i] = 0; end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 32'(rsp_valid), 0, "response during reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", 32'(rsp_valid), 0, "response after reset");

    // R1: memory zero after reset
    run(0, 0, 0, 0, g);  check("R1", g, 0, "word 0");
    run(1, 0, 9, 0, g);  check("R1", g, 0, "word 9");
    run(3, 0, 15, 0, g); check("R1", g, 0, "word 15");
    // R1: no reservation, conditional store fails
    run(2, 6, 4, 32'h11, g); check("R1", g, 0, "no reservation");

    // R2: latency from an idle unit
    @(negedge clk);
    post(1, 0, 3, 0);
    @(negedge clk); check("R2", 32'(rsp_valid), 0, "after one edge");
    @(negedge clk); check("R2", 32'(rsp_valid), 32'h2, "after two edges");
    @(negedge clk);

    // R4 store / load
    run(0, 1, 5, 32'hA5A5_0001, g); check("R4", g, 0, "store result");
    run(2, 0, 5, 0, g);             check("R4", g, 32'hA5A5_0001, "load back");
    // R5 swap
    run(3, 2, 5, 32'h77, g); check("R5", g, 32'hA5A5_0001, "swap old");
    run(0, 0, 5, 0, g);      check("R5", g, 32'h77, "swap new");
    // R6 test-and-set
    run(1, 3, 6, 0, g); check("R6", g, 0, "free lock");
    run(2, 3, 6, 0, g); check("R6", g, 1, "held lock");
    run(0, 1, 6, 5, g);
    run(3, 3, 6, 0, g); check("R6", g, 5, "nonzero old");
    run(1, 0, 6, 0, g); check("R6", g, 5, "nonzero unchanged");
    // R7 increment with wrap
    run(0, 1, 7, 32'hFFFF_FFFE, g);
    run(1, 4, 7, 0, g); check("R7", g, 32'hFFFF_FFFE, "inc 1");
    run(2, 4, 7, 0, g); check("R7", g, 32'hFFFF_FFFF, "inc 2");
    run(3, 4, 7, 0, g); check("R7", g, 32'h0, "inc wraps");
    run(0, 0, 7, 0, g); check("R7", g, 32'h1, "after wrap");
    // R8 / R9 linked pair success
    run(1, 5, 8, 0, g);     check("R8", g, 0, "linked load");
    run(1, 6, 8, 32'h55, g); check("R9", g, 1, "cond store ok");
    run(0, 0, 8, 0, g);     check("R9", g, 32'h55, "cond store wrote");
    // R10 failure leaves memory
    run(2, 6, 9, 32'h66, g); check("R10", g, 0, "cond store fail");
    run(3, 0, 9, 0, g);      check("R10", g, 0, "no write");
    // R11 write cancels every reservation on that address only
    run(0, 5, 10, 0, g);
    run(1, 5, 10, 0, g);
    run(3, 5, 11, 0, g);
    run(2, 2, 10, 3, g);
    run(0, 6, 10, 9, g); check("R11", g, 0, "req0 cancelled");
    run(1, 6, 10, 9, g); check("R11", g, 0, "req1 cancelled");
    run(3, 6, 11, 4, g); check("R11", g, 1, "other address kept");
    run(2, 0, 10, 0, g); check("R11", g, 3, "swap value stays");
    run(0, 5, 12, 0, g);
    run(0, 4, 12, 0, g);
    run(0, 6, 12, 1, g); check("R11", g, 0, "own increment cancels");
    // R12 conditional store drops own reservation
    run(2, 5, 13, 0, g);
    run(2, 6, 13, 1, g); check("R12", g, 1, "first store");
    run(2, 6, 13, 2, g); check("R12", g, 0, "second store");
    run(2, 0, 13, 0, g); check("R12", g, 1, "value kept");

    // R3 full contention, increments
    @(negedge clk);
    order_q.delete();
    exp_r = last_served;
    for (int r = 0; r < N; r++) begin s[r] = done_cnt[r]; post(r, 4, 14, 0); end
    wait (done_cnt[0] != s[0] && done_cnt[1] != s[1] && done_cnt[2] != s[2] && done_cnt[3] != s[3]);
    for (int k = 0; k < N; k++)
      check("R3", 32'(order_q[k]), 32'((exp_r + 1 + k) % N), $sformatf("order slot %0d", k));
    run(1, 0, 14, 0, g); check("R3", g, 4, "all increments applied");

    // R3 / R6 lock contention by test-and-set
    @(negedge clk);
    order_q.delete();
    exp_r = last_served;
    for (int r = 0; r < N; r++) begin s[r] = done_cnt[r]; post(r, 3, 15, 0); end
    wait (done_cnt[0] != s[0] && done_cnt[1] != s[1] && done_cnt[2] != s[2] && done_cnt[3] != s[3]);
    zeros = 0;
    for (int r = 0; r < N; r++) if (last_rsp[r] == 0) zeros++;
    check("R6", 32'(zeros), 1, "single lock winner");
    for (int k = 0; k < N; k++)
      check("R3", 32'(order_q[k]), 32'((exp_r + 1 + k) % N), $sformatf("tas slot %0d", k));

    // R3 partial contention: requesters 1 and 3
    @(negedge clk);
    order_q.delete();
    exp_r = -1;
    for (int k = 1; k <= N; k++)
      if (exp_r < 0 && (((last_served + k) % N) == 1 || ((last_served + k) % N) == 3))
        exp_r = (last_served + k) % N;
    s[1] = done_cnt[1]; s[3] = done_cnt[3];
    post(1, 0, 2, 0); post(3, 0, 2, 0);
    wait (done_cnt[1] != s[1] && done_cnt[3] != s[3]);
    check("R3", 32'(order_q[0]), 32'(exp_r), "partial first");
    check("R3", 32'(order_q[1]), 32'((exp_r == 1) ? 3 : 1), "partial second");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule